// File: doc/BRIEF.md
# Serial Bus Pause Gate

This block sits between the pins of a serial peripheral port and the slave state machine that shifts data in and out. It resamples the clock, select, pause and data-in pins into the core clock domain. From them it derives one strobe per qualified serial clock rising edge, one per qualified falling edge, and an enable for the data-out driver. A host that shares the serial clock with other devices can drive the active-low pause pin to freeze a transfer part way through. The frame is not aborted, and when the pause pin is released the slave continues with the same bit.

The pause state changes only while the resampled serial clock is low. A pause request made while the clock is high waits until the clock is next seen low, and so does a release. This means a bit is never half-clocked. While paused, clock and data-in activity produce no strobes, the bit position counter holds, and the data-out enable is dropped. Raising the select pin ends the frame: it clears the pause and the bit position, so the next frame always starts running at bit 0.

Top module: `pause_gate`

## Requirements
- R1: After reset, with the select pin high, `so_oe_o` is 0, `paused_o` is 0, `bit_pos_o` is 0, and neither strobe fires.
- R2: While selected (`cs_n_i` low) and running, each serial clock rising edge gives exactly one `rise_en_o` pulse, with the data-in level on `sample_o` during that pulse. `bit_pos_o` then advances by one and wraps from `FRAME_BITS-1` to 0, and `word_done_o` pulses together with the rise that ends a word.
- R3: While selected and running, each serial clock falling edge gives exactly one `fall_en_o` pulse.
- R4: Driving `hold_n_i` low while the serial clock is low sets `paused_o` to 1 and `so_oe_o` to 0.
- R5: Driving `hold_n_i` low while the serial clock is high leaves the block running, with `so_oe_o` still 1, until the clock goes low. The falling edge that ends the high phase still gives its `fall_en_o` pulse, and the pause starts right after it.
- R6: While paused, serial clock and data-in transitions give no `rise_en_o` and no `fall_en_o`, and `bit_pos_o` holds its value.
- R7: Driving `hold_n_i` high while the clock is low clears `paused_o` and restores `so_oe_o`. If the clock is high at that moment, the block stays paused until the clock is low, and that falling edge gives no strobe.
- R8: After a pause, shifting continues from the bit position held at pause entry, so a word split by a pause is received intact.
- R9: Driving `cs_n_i` high clears `paused_o` and returns `bit_pos_o` to 0. A new frame with `hold_n_i` high then starts unpaused, with `so_oe_o` at 1.
- R10: While `cs_n_i` is high, clock and pause pin activity give no strobes, `so_oe_o` stays 0 and `paused_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low select pin |
| hold_n_i | input | 1 | Active-low pause pin |
| si_i | input | 1 | Serial data-in pin |
| rise_en_o | output | 1 | Qualified rising-edge strobe for input shifting |
| fall_en_o | output | 1 | Qualified falling-edge strobe for output shifting |
| sample_o | output | 1 | Resampled data-in level, valid with `rise_en_o` |
| so_oe_o | output | 1 | Data-out driver enable |
| paused_o | output | 1 | Transfer is frozen |
| bit_pos_o | output | POS_W | Bit position within the current word |
| word_done_o | output | 1 | Pulses with the rise that completes a word |

## Verification
Pause entry and the falling-edge strobe can fall in the same core cycle. This happens when the pause pin drops during the clock's high phase and the clock then falls. The bench sets up exactly that: it lowers the pause pin with the clock high and confirms the block still runs, then lowers the clock. It expects exactly one extra falling strobe, a paused state, and no further strobes while the clock toggles. The bench also sweeps the pause entry point over every bit position of a word, for two data patterns. Each time it rebuilds the received word from the rising strobes and compares it with the word that was sent.

// File: rtl/pause_gate_pkg.sv
package pause_gate_pkg;

    typedef enum logic {
        GATE_RUN  = 1'b0,
        GATE_HOLD = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic hold_n;
        logic si;
    } pin_bus_t;

    localparam int PIN_W = $bits(pin_bus_t);

    localparam pin_bus_t PIN_IDLE = '{sck: 1'b0, cs_n: 1'b1, hold_n: 1'b1, si: 1'b0};

    function automatic pin_bus_t make_pins(input logic sck, input logic cs_n,
                                           input logic hold_n, input logic si);
        pin_bus_t p;
        p.sck    = sck;
        p.cs_n   = cs_n;
        p.hold_n = hold_n;
        p.si     = si;
        return p;
    endfunction

endpackage

// File: rtl/pause_gate_sync.sv
module pause_gate_sync
    import pause_gate_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  pin_bus_t raw_i,
    output pin_bus_t synced_o
);
    logic [PIN_W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= PIN_IDLE;
                else     stage_q[g] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= PIN_IDLE;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign synced_o = pin_bus_t'(stage_q[STAGES-1]);
endmodule

// File: rtl/pause_gate_edge.sv
module pause_gate_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
    assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/pause_gate_fsm.sv
module pause_gate_fsm
    import pause_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_i,
    input  logic        sck_i,
    input  logic        hold_n_i,
    output gate_state_e state_o
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!sel_i) begin
            state_d = GATE_RUN;
        end else begin
            unique case (state_q)
                GATE_RUN:  if (!hold_n_i && !sck_i) state_d = GATE_HOLD;
                GATE_HOLD: if (hold_n_i && !sck_i)  state_d = GATE_RUN;
                default:   state_d = GATE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= GATE_RUN;
        else     state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/pause_gate_bitpos.sv
module pause_gate_bitpos #(
    parameter int FRAME_BITS = 8,
    parameter int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_i,
    input  logic             step_i,
    output logic [POS_W-1:0] pos_o,
    output logic             wrap_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            pos_q <= '0;
        end else if (step_i) begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
        end
    end

    assign pos_o  = pos_q;
    assign wrap_o = step_i && (pos_q == LAST_POS);
endmodule

// File: rtl/pause_gate.sv
module pause_gate
    import pause_gate_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FRAME_BITS  = 8,
    parameter int POS_W       = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_i,
    input  logic             cs_n_i,
    input  logic             hold_n_i,
    input  logic             si_i,
    output logic             rise_en_o,
    output logic             fall_en_o,
    output logic             sample_o,
    output logic             so_oe_o,
    output logic             paused_o,
    output logic [POS_W-1:0] bit_pos_o,
    output logic             word_done_o
);
    pin_bus_t    s_pins;
    gate_state_e gate_state;
    logic        sel;
    logic        running;
    logic        sck_rise;
    logic        sck_fall;

    pause_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_i    (make_pins(sck_i, cs_n_i, hold_n_i, si_i)),
        .synced_o (s_pins)
    );

    assign sel = ~s_pins.cs_n;

    pause_gate_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (s_pins.sck),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    pause_gate_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sel_i    (sel),
        .sck_i    (s_pins.sck),
        .hold_n_i (s_pins.hold_n),
        .state_o  (gate_state)
    );

    assign running   = sel && (gate_state == GATE_RUN);
    assign rise_en_o = sck_rise && running;
    assign fall_en_o = sck_fall && running;
    assign sample_o  = s_pins.si;
    assign so_oe_o   = running;
    assign paused_o  = (gate_state == GATE_HOLD);

    pause_gate_bitpos #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_pos (
        .clk    (clk),
        .rst    (rst),
        .sel_i  (sel),
        .step_i (rise_en_o),
        .pos_o  (bit_pos_o),
        .wrap_o (word_done_o)
    );
endmodule

// File: rtl/pause_gate_chk.sv
module pause_gate_chk #(
    parameter int POS_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             sck_lvl,
    input logic             sel_lvl,
    input logic             rise_en_o,
    input logic             fall_en_o,
    input logic             so_oe_o,
    input logic             paused_o,
    input logic [POS_W-1:0] bit_pos_o,
    input logic             word_done_o
);
    AST_PAUSE_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(paused_o) |-> !$past(sck_lvl)); // R4

    AST_PAUSED_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        paused_o |-> !so_oe_o); // R4

    AST_PAUSED_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        paused_o |-> !(rise_en_o || fall_en_o)); // R6

    AST_PAUSED_POS_HELD: assert property (@(posedge clk) disable iff (rst)
        (paused_o && $past(paused_o)) |-> $stable(bit_pos_o)); // R6

    AST_RESUME_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(paused_o) |-> (!$past(sck_lvl) || !$past(sel_lvl))); // R7

    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !sel_lvl |=> (!paused_o && bit_pos_o == '0)); // R9

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sel_lvl |-> !(rise_en_o || fall_en_o || so_oe_o)); // R10

    AST_WORD_DONE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        word_done_o |-> (rise_en_o && $countones(bit_pos_o) == POS_W)); // R2
endmodule

bind pause_gate pause_gate_chk #(.POS_W(POS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sck_lvl     (s_pins.sck),
    .sel_lvl     (sel),
    .rise_en_o   (rise_en_o),
    .fall_en_o   (fall_en_o),
    .so_oe_o     (so_oe_o),
    .paused_o    (paused_o),
    .bit_pos_o   (bit_pos_o),
    .word_done_o (word_done_o)
);

// File: tb/test_pause_gate.sv
module test_pause_gate;
    localparam int FB = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
    logic rise_en, fall_en, sample, so_oe, paused, word_done;
    logic [PW-1:0] bit_pos;

    int checks = 0;
    int errors = 0;
    int rise_cnt = 0;
    int fall_cnt = 0;
    int word_cnt = 0;
    logic [7:0] rx = '0;
    bit done = 0;

    always #10 clk = ~clk;

    pause_gate #(.SYNC_STAGES(2), .FRAME_BITS(FB)) i_pause_gate (
        .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
        .si_i(si), .rise_en_o(rise_en), .fall_en_o(fall_en), .sample_o(sample),
        .so_oe_o(so_oe), .paused_o(paused), .bit_pos_o(bit_pos),
        .word_done_o(word_done)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rise_en) begin
                rise_cnt <= rise_cnt + 1;
                rx <= {rx[6:0], sample};
            end
            if (fall_en) fall_cnt <= fall_cnt + 1;
            if (word_done) word_cnt <= word_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #5;
    endtask

    task automatic shift_bit(input logic b);
        si = b;  settle();
        sck = 1'b1; settle();
        sck = 1'b0; settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0, f0, p0;
        logic [7:0] pat [2];
        pat[0] = 8'hA5;
        pat[1] = 8'h3C;

        repeat (4) @(posedge clk);
        #5 rst = 1'b0;
        settle();
        // R1: reset state
        check(so_oe == 1'b0, "R1 oe", so_oe, 0);
        check(paused == 1'b0, "R1 paused", paused, 0);
        check(bit_pos == 0, "R1 pos", bit_pos, 0);
        check(rise_cnt == 0 && fall_cnt == 0, "R1 strobes", rise_cnt + fall_cnt, 0);

        // R10: deselected activity is ignored
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; settle();
            hold_n = 1'b0; settle();
            sck = 1'b0; settle();
            hold_n = 1'b1; settle();
        end
        check(rise_cnt == 0 && fall_cnt == 0, "R10 strobes", rise_cnt + fall_cnt, 0);
        check(so_oe == 1'b0, "R10 oe", so_oe, 0);
        check(paused == 1'b0, "R10 paused", paused, 0);

        // Sweep: pause at every bit position, two patterns (R2 R3 R4 R6 R7 R8 R9)
        for (int pi = 0; pi < 2; pi++) begin
            for (int p = 0; p < FB; p++) begin
                int w0;
                w0 = word_cnt;
                cs_n = 1'b0; settle();
                check(so_oe == 1'b1, "R9 new frame oe", so_oe, 1);
                check(bit_pos == 0, "R9 new frame pos", bit_pos, 0);
                r0 = rise_cnt; f0 = fall_cnt;
                for (int b = 0; b < p; b++) shift_bit(pat[pi][7-b]);
                check(rise_cnt - r0 == p, "R2 rise count", rise_cnt - r0, p);
                check(fall_cnt - f0 == p, "R3 fall count", fall_cnt - f0, p);
                check(int'(bit_pos) == p, "R2 pos", bit_pos, p);
                hold_n = 1'b0; settle();
                check(paused == 1'b1, "R4 paused", paused, 1);
                check(so_oe == 1'b0, "R4 oe", so_oe, 0);
                r0 = rise_cnt; f0 = fall_cnt;
                for (int t = 0; t < 3; t++) begin
                    si = ~si; sck = 1'b1; settle();
                    sck = 1'b0; settle();
                end
                check(rise_cnt == r0 && fall_cnt == f0, "R6 strobes", rise_cnt - r0 + fall_cnt - f0, 0);
                check(int'(bit_pos) == p, "R6 pos", bit_pos, p);
                hold_n = 1'b1; settle();
                check(paused == 1'b0 && so_oe == 1'b1, "R7 resume", paused, 0);
                for (int b = p; b < FB; b++) shift_bit(pat[pi][7-b]);
                check(rx == pat[pi], "R8 word", rx, pat[pi]);
                check(word_cnt - w0 == 1, "R2 word_done", word_cnt - w0, 1);
                check(bit_pos == 0, "R2 wrap", bit_pos, 0);
                // leave a partial word then deselect while paused
                shift_bit(1'b1);
                hold_n = 1'b0; settle();
                cs_n = 1'b1; settle();
                check(paused == 1'b0, "R9 paused", paused, 0);
                check(bit_pos == 0, "R9 pos", bit_pos, 0);
                hold_n = 1'b1; settle();
            end
        end

        // R5 and same-cycle fall plus pause entry
        cs_n = 1'b0; settle();
        shift_bit(1'b0); shift_bit(1'b1);
        si = 1'b1; sck = 1'b1; settle();
        check(int'(bit_pos) == 3, "R5 pos", bit_pos, 3);
        hold_n = 1'b0; settle();
        check(paused == 1'b0, "R5 deferred", paused, 0);
        check(so_oe == 1'b1, "R5 oe", so_oe, 1);
        f0 = fall_cnt; r0 = rise_cnt;
        sck = 1'b0; settle();
        check(fall_cnt - f0 == 1, "R5 final fall", fall_cnt - f0, 1);
        check(paused == 1'b1, "R5 entered", paused, 1);
        // R7: release while clock high is deferred
        sck = 1'b1; settle();
        hold_n = 1'b1; settle();
        check(paused == 1'b1, "R7 deferred", paused, 1);
        f0 = fall_cnt;
        sck = 1'b0; settle();
        check(paused == 1'b0, "R7 resumed", paused, 0);
        check(fall_cnt == f0, "R7 no fall", fall_cnt - f0, 0);
        check(rise_cnt == r0, "R6 no rise", rise_cnt - r0, 0);
        p0 = int'(bit_pos);
        check(p0 == 3, "R8 pos kept", p0, 3);
        shift_bit(1'b0);
        check(int'(bit_pos) == 4, "R8 continue", bit_pos, 4);
        check(rise_cnt - r0 == 1, "R2 single rise", rise_cnt - r0, 1);
        cs_n = 1'b1; settle();
        check(bit_pos == 0 && so_oe == 1'b0, "R9 end", bit_pos, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule